// File: doc/BRIEF.md
# Register-Programmed Clock Rate Divider

This block divides an input clock-enable stream (`in_tick`) by an integer that software sets through a 32-bit control word. The divide code sits in a field at a compile-time bit offset within that word. One of four compile-time encodings turns the code into a divisor:
- the code plus one;
- the code itself;
- two to the power of the code;
- a lookup table in which a zero entry marks an illegal code.

The block produces two outputs. `div_tick` is a one-cycle enable once per divided period. `div_clk` is a level that can serve as the divided clock. The output is never gated.

A write with an illegal or out-of-range code leaves the divisor alone and raises a sticky error flag. A divisor change takes effect only at the end of the current divided period, so no runt pulse ever appears. When the latch option is built in, a valid write is only staged, and it is committed by a later write that sets the latch bit. The same control word carries an autoidle bit at its own position, with polarity inversion as a build option.

All pins are plain control and status. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. `cfg_wr` is a single-cycle strobe that is always accepted.

Top module: `clk_ratediv`

## Requirements
- R1: After reset the divisor (`cur_div`) is 1, `cfg_err` is 0, the stored autoidle bit is 0 (so `autoidle_on` equals IDLE_INV), and the outputs follow `in_tick` directly.
- R2: With ENC_MINUS1 the divisor is code + 1 (code 0 divides by 1, code 2 by 3).
- R3: With ENC_DIRECT the divisor equals the code, and code 0 is illegal.
- R4: With ENC_POW2 the divisor is 2 to the power of the code (code 0 gives 1, code 3 gives 8).
- R5: With ENC_TABLE the divisor is table entry `code`, taken from TABLE bits [code*DIV_W +: DIV_W]. A zero entry is an illegal code, and `cur_div` is never 0.
- R6: In every mode except ENC_TABLE, a divisor below MIN_DIV or above MAX_DIV is illegal. ENC_TABLE ignores both limits.
- R7: A write with an illegal code changes neither the staged nor the current divisor, and it sets `cfg_err`. `cfg_err` then stays set until reset.
- R8: The code is read from `cfg_wdata[FIELD_LSB +: FIELD_W]`. Apart from the latch and autoidle bits, every other bit of the word has no effect.
- R9: With LATCH_EN=0, each valid write requests a commit. With LATCH_EN=1, a write that clears bit LATCH_POS only stages its code. A write that sets bit LATCH_POS requests a commit of the newest staged value, which is that write's own code if that code is valid.
- R10: A requested divisor is applied at the `in_tick` that ends the current period, and the new period starts from phase 0. A request made in the very cycle of a period end waits for the next period end.
- R11: `div_tick` is high in the cycle of the N-th `in_tick` of each period and never without `in_tick`. When N is 1, `div_tick` equals `in_tick` in the same cycle.
- R12: For N > 1, `div_clk` is high while the phase (the number of `in_tick`s since the period start) is at least N - floor(N/2). For N = 1, `div_clk` equals `in_tick`.
- R13: `autoidle_on` equals bit IDLE_POS of the latest write XOR IDLE_INV. Every write updates it, whether its code is valid or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word written on `cfg_wr` |
| in_tick | input | 1 | Input clock enable to be divided |
| div_tick | output | 1 | One-cycle enable at the end of each divided period |
| div_clk | output | 1 | Divided clock level |
| cur_div | output | DIV_W | Divisor currently in use |
| cfg_err | output | 1 | Sticky flag: an illegal code was written |
| autoidle_on | output | 1 | Autoidle active, polarity already applied |

## Verification
The bench targets several corner cases:
- A write that lands in the same cycle as a period end. A design that applies it at once would shorten that period.
- Table codes whose entry is zero, and codes whose divisor falls just past the limits. A design that accepted them would load a divisor of zero or out of range and lock up or misdivide.
- Words with every bit outside the code field set. A design with a wrong field offset would pick up a wrong divisor.
- In latch mode, staged writes that never commit on their own.
- Invalid writes that must still update the autoidle bit.

Odd divisors and divide-by-1 are compared on every cycle, because an off-by-one in the high-phase threshold or in the pass-through shows up as a skewed or missing `div_clk` edge.

// File: rtl/clk_ratediv_pkg.sv
package clk_ratediv_pkg;
  typedef enum logic [1:0] {
    ENC_MINUS1 = 2'd0,
    ENC_DIRECT = 2'd1,
    ENC_POW2   = 2'd2,
    ENC_TABLE  = 2'd3
  } div_enc_e;
endpackage

// File: rtl/clk_ratediv_decode.sv
// Translates a divide code into a divisor and a legality flag.
module clk_ratediv_decode
  import clk_ratediv_pkg::*;
#(
  parameter div_enc_e MODE = ENC_MINUS1,
  parameter int FIELD_W = 4,
  parameter int DIV_W = 8,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 16,
  parameter logic [(1<<FIELD_W)*DIV_W-1:0] TABLE = '0
) (
  input  logic [FIELD_W-1:0] code,
  output logic [DIV_W-1:0]   div,
  output logic               ok
);
  localparam int N_ENT = 1 << FIELD_W;
  localparam logic [31:0] DIV_CEIL = (32'd1 << DIV_W) - 32'd1;

  logic [31:0] raw;

  generate
    if (MODE == ENC_TABLE) begin : g_table
      logic [DIV_W-1:0] tbl [N_ENT];
      for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        assign tbl[i] = TABLE[i*DIV_W +: DIV_W];
      end
      always_comb begin
        raw = 32'(tbl[code]);
        ok  = (raw != 32'd0);
      end
    end else begin : g_arith
      always_comb begin
        case (MODE)
          ENC_DIRECT: raw = 32'(code);
          ENC_POW2:   raw = 32'd1 << code;
          default:    raw = 32'(code) + 32'd1;
        endcase
        ok = (raw != 32'd0) && (raw >= 32'(MIN_DIV)) &&
             (raw <= 32'(MAX_DIV)) && (raw <= DIV_CEIL);
      end
    end
  endgenerate

  assign div = raw[DIV_W-1:0];
endmodule

// File: rtl/clk_ratediv_cfg.sv
// Control word capture: decoding, staging, error flag, autoidle bit.
module clk_ratediv_cfg
  import clk_ratediv_pkg::*;
#(
  parameter div_enc_e MODE = ENC_MINUS1,
  parameter int FIELD_LSB = 0,
  parameter int FIELD_W = 4,
  parameter int DIV_W = 8,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 16,
  parameter bit LATCH_EN = 1'b0,
  parameter int LATCH_POS = 31,
  parameter int IDLE_POS = 30,
  parameter bit IDLE_INV = 1'b0,
  parameter int RESET_DIV = 1,
  parameter logic [(1<<FIELD_W)*DIV_W-1:0] TABLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [31:0]      wdata,
  output logic             req,
  output logic [DIV_W-1:0] req_div,
  output logic             err,
  output logic             idle_on
);
  logic [FIELD_W-1:0] code;
  logic [DIV_W-1:0]   dec_div;
  logic               dec_ok;
  logic [DIV_W-1:0]   stage_q;
  logic               err_q;
  logic               idle_q;
  logic               wdata_unused;

  assign code = wdata[FIELD_LSB +: FIELD_W];
  assign wdata_unused = ^wdata;

  clk_ratediv_decode #(
    .MODE(MODE), .FIELD_W(FIELD_W), .DIV_W(DIV_W),
    .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .TABLE(TABLE)
  ) u_decode (
    .code(code), .div(dec_div), .ok(dec_ok)
  );

  always_comb begin
    if (LATCH_EN) req = wr && wdata[LATCH_POS];
    else          req = wr && dec_ok;
    req_div = dec_ok ? dec_div : stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= DIV_W'(RESET_DIV);
      err_q   <= 1'b0;
      idle_q  <= 1'b0;
    end else if (wr) begin
      idle_q <= wdata[IDLE_POS];
      if (dec_ok) stage_q <= dec_div;
      else        err_q   <= 1'b1;
    end
  end

  assign err     = err_q;
  assign idle_on = idle_q ^ IDLE_INV;

  // R7
  bad_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !dec_ok) |=> $stable(stage_q));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/clk_ratediv_core.sv
// Phase counter, boundary-aligned divisor commit, divided outputs.
module clk_ratediv_core #(
  parameter int DIV_W = 8,
  parameter int RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_tick,
  input  logic             req,
  input  logic [DIV_W-1:0] req_div,
  output logic             div_tick,
  output logic             div_clk,
  output logic [DIV_W-1:0] cur_div
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cur_q, pend_q;
  logic             armed_q;
  logic             at_last, bnd;

  assign at_last = (cnt_q == cur_q - ONE);
  assign bnd     = in_tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cur_q   <= DIV_W'(RESET_DIV);
      pend_q  <= DIV_W'(RESET_DIV);
      armed_q <= 1'b0;
    end else begin
      if (in_tick) cnt_q <= bnd ? '0 : cnt_q + ONE;
      if (bnd && armed_q) cur_q <= pend_q;
      if (req) begin
        armed_q <= 1'b1;
        pend_q  <= req_div;
      end else if (bnd) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign div_tick = bnd;
  assign div_clk  = (cur_q == ONE) ? in_tick : (cnt_q >= cur_q - (cur_q >> 1));
  assign cur_div  = cur_q;

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cur_q);
  // R10
  cur_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> $past(bnd));
  // R5
  no_zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q != '0);
endmodule

// File: rtl/clk_ratediv.sv
module clk_ratediv
  import clk_ratediv_pkg::*;
#(
  parameter div_enc_e MODE = ENC_MINUS1,
  parameter int FIELD_LSB = 0,
  parameter int FIELD_W = 4,
  parameter int DIV_W = 8,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 16,
  parameter bit LATCH_EN = 1'b0,
  parameter int LATCH_POS = 31,
  parameter int IDLE_POS = 30,
  parameter bit IDLE_INV = 1'b0,
  parameter int RESET_DIV = 1,
  parameter logic [(1<<FIELD_W)*DIV_W-1:0] TABLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  input  logic             in_tick,
  output logic             div_tick,
  output logic             div_clk,
  output logic [DIV_W-1:0] cur_div,
  output logic             cfg_err,
  output logic             autoidle_on
);
  logic             req;
  logic [DIV_W-1:0] req_div;

  clk_ratediv_cfg #(
    .MODE(MODE), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .DIV_W(DIV_W),
    .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .LATCH_EN(LATCH_EN),
    .LATCH_POS(LATCH_POS), .IDLE_POS(IDLE_POS), .IDLE_INV(IDLE_INV),
    .RESET_DIV(RESET_DIV), .TABLE(TABLE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .req(req), .req_div(req_div), .err(cfg_err), .idle_on(autoidle_on)
  );

  clk_ratediv_core #(
    .DIV_W(DIV_W), .RESET_DIV(RESET_DIV)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .in_tick(in_tick), .req(req), .req_div(req_div),
    .div_tick(div_tick), .div_clk(div_clk), .cur_div(cur_div)
  );
endmodule

// File: tb/clk_ratediv_bench.sv
// One DUT plus a behavioural model, compared on every cycle.
module clk_ratediv_harness #(
  parameter int MODE_I = 0,
  parameter int FLSB = 0,
  parameter int FW = 4,
  parameter int MIN_D = 1,
  parameter int MAX_D = 16,
  parameter bit LATCH = 1'b0,
  parameter int LPOS = 31,
  parameter int IPOS = 30,
  parameter bit INV = 1'b0,
  parameter logic [(1<<FW)*8-1:0] TBL = '0,
  parameter string MTAG = "R2"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        in_tick,
  output logic [7:0]  o_div,
  output logic        o_err,
  output logic        o_idle
);
  logic div_tick, div_clk;
  int n_chk = 0;
  int n_bad = 0;

  clk_ratediv #(
    .MODE(clk_ratediv_pkg::div_enc_e'(MODE_I)), .FIELD_LSB(FLSB), .FIELD_W(FW),
    .DIV_W(8), .MIN_DIV(MIN_D), .MAX_DIV(MAX_D), .LATCH_EN(LATCH),
    .LATCH_POS(LPOS), .IDLE_POS(IPOS), .IDLE_INV(INV), .RESET_DIV(1), .TABLE(TBL)
  ) u_clk_ratediv (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr), .cfg_wdata(wdata), .in_tick(in_tick),
    .div_tick(div_tick), .div_clk(div_clk), .cur_div(o_div),
    .cfg_err(o_err), .autoidle_on(o_idle)
  );

  // Table model kept as an explicit list (entry i -> divisor)
  function automatic int tbl_ref(int i);
    case (i)
      0: return 3;  2: return 5;  3: return 1;  5: return 7;
      6: return 2;  8: return 9;  9: return 4;  10: return 6;
      12: return 8; 13: return 1; 14: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic void m_dec(input int f, output int d, output bit ok);
    case (MODE_I)
      0: d = f + 1;
      1: d = f;
      2: d = 1 << f;
      default: d = tbl_ref(f);
    endcase
    if (MODE_I == 3) ok = (d != 0);
    else ok = (d != 0) && (d >= MIN_D) && (d <= MAX_D) && (d <= 255);
  endfunction

  int m_cur, m_cnt, m_stage, m_pend;
  bit m_armed, m_err, m_idle;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 1; m_cnt = 0; m_stage = 1; m_pend = 1;
      m_armed = 0; m_err = 0; m_idle = 0;
    end else begin
      int f, d, nv;
      bit ok, bnd, req;
      bnd = in_tick && (m_cnt == m_cur - 1);
      f = int'(wdata >> FLSB) & ((1 << FW) - 1);
      m_dec(f, d, ok);
      if (in_tick) m_cnt = bnd ? 0 : m_cnt + 1;
      if (bnd && m_armed) m_cur = m_pend;
      req = wr && (LATCH ? wdata[LPOS] : ok);
      nv = ok ? d : m_stage;
      if (req) begin m_armed = 1; m_pend = nv; end
      else if (bnd) m_armed = 0;
      if (wr) begin
        if (ok) m_stage = d; else m_err = 1;
        m_idle = wdata[IPOS];
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s mode%0d act=%0d exp=%0d t=%0t", what, MODE_I, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_tick, e_clk;
      e_tick = in_tick && (m_cnt == m_cur - 1);
      e_clk = (m_cur == 1) ? in_tick : (m_cnt >= m_cur - m_cur / 2);
      cmp("R11 div_tick", int'(div_tick), int'(e_tick));
      cmp("R12 div_clk", int'(div_clk), int'(e_clk));
      cmp({MTAG, "/R10 cur_div"}, int'(o_div), m_cur);
      cmp("R7 cfg_err", int'(o_err), int'(m_err));
      cmp("R13 autoidle_on", int'(o_idle), int'(m_idle ^ INV));
    end
  end
endmodule

module clk_ratediv_bench;
  localparam int CLK_P = 10;
  localparam logic [127:0] D_TBL = {8'd0, 8'd12, 8'd1, 8'd8, 8'd0, 8'd6, 8'd4, 8'd9,
                                    8'd0, 8'd2, 8'd7, 8'd0, 8'd1, 8'd5, 8'd0, 8'd3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] wr = '0;
  logic [31:0] wdata = '0;
  logic in_tick = 1'b1;
  logic [7:0] a_div, b_div, c_div, d_div;
  logic a_err, b_err, c_err, d_err, a_idle, b_idle, c_idle, d_idle;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  clk_ratediv_harness #(.MODE_I(0), .FLSB(8), .FW(4), .MAX_D(12), .IPOS(0), .MTAG("R2"))
    h_a (.clk(clk), .rst_n(rst_n), .wr(wr[0]), .wdata(wdata), .in_tick(in_tick),
         .o_div(a_div), .o_err(a_err), .o_idle(a_idle));
  clk_ratediv_harness #(.MODE_I(1), .FLSB(0), .FW(4), .MAX_D(10), .LATCH(1'b1),
                        .LPOS(31), .IPOS(30), .INV(1'b1), .MTAG("R3"))
    h_b (.clk(clk), .rst_n(rst_n), .wr(wr[1]), .wdata(wdata), .in_tick(in_tick),
         .o_div(b_div), .o_err(b_err), .o_idle(b_idle));
  clk_ratediv_harness #(.MODE_I(2), .FLSB(4), .FW(3), .MAX_D(32), .IPOS(0), .MTAG("R4"))
    h_c (.clk(clk), .rst_n(rst_n), .wr(wr[2]), .wdata(wdata), .in_tick(in_tick),
         .o_div(c_div), .o_err(c_err), .o_idle(c_idle));
  clk_ratediv_harness #(.MODE_I(3), .FLSB(28), .FW(4), .MAX_D(4), .IPOS(0),
                        .TBL(D_TBL), .MTAG("R5"))
    h_d (.clk(clk), .rst_n(rst_n), .wr(wr[3]), .wdata(wdata), .in_tick(in_tick),
         .o_div(d_div), .o_err(d_err), .o_idle(d_idle));

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_cfg(int idx, logic [31:0] d);
    @(posedge clk); #1;
    wr = '0; wr[idx] = 1'b1; wdata = d;
    @(posedge clk); #1;
    wr = '0;
  endtask

  task automatic finish_up();
    n_chk += h_a.n_chk + h_b.n_chk + h_c.n_chk + h_d.n_chk;
    n_bad += h_a.n_bad + h_b.n_bad + h_c.n_bad + h_d.n_bad;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    run(3);
    // R1 reset state
    chk("R1 a cur_div", int'(a_div), 1);
    chk("R1 d cur_div", int'(d_div), 1);
    chk("R1 b cfg_err", int'(b_err), 0);
    chk("R1 a autoidle", int'(a_idle), 0);
    chk("R1 b autoidle inverted", int'(b_idle), 1);

    wr_cfg(0, 32'h0000_0300); run(40);
    chk("R2 code 3 -> 4", int'(a_div), 4);
    wr_cfg(0, 32'hFFFF_F2FE); run(40);
    chk("R8 outside bits ignored, code 2 -> 3", int'(a_div), 3);
    chk("R13 a idle bit 0", int'(a_idle), 0);
    wr_cfg(0, 32'h0000_0F01); run(40);
    chk("R6 code 15 above max kept", int'(a_div), 3);
    chk("R7 a error set", int'(a_err), 1);
    chk("R13 idle updated on bad write", int'(a_idle), 1);

    wr_cfg(1, 32'h0000_0005); run(40);
    chk("R9 staged only", int'(b_div), 1);
    chk("R9 no error", int'(b_err), 0);
    wr_cfg(1, 32'hC000_0006); run(40);
    chk("R9 latch commit", int'(b_div), 6);
    chk("R13 inverted idle", int'(b_idle), 0);
    wr_cfg(1, 32'h8000_0000); run(40);
    chk("R3 code 0 illegal keeps div", int'(b_div), 6);
    chk("R3 code 0 sets error", int'(b_err), 1);

    wr_cfg(2, 32'h0000_0030); run(60);
    chk("R4 code 3 -> 8", int'(c_div), 8);
    wr_cfg(2, 32'h0000_0070); run(60);
    chk("R6 pow2 128 above max kept", int'(c_div), 8);
    chk("R6 pow2 error", int'(c_err), 1);

    wr_cfg(3, 32'h2000_0000); run(40);
    chk("R6 table ignores max, entry 2 -> 5", int'(d_div), 5);
    wr_cfg(3, 32'h1000_0000); run(40);
    chk("R5 zero entry kept", int'(d_div), 5);
    chk("R5 zero entry error", int'(d_err), 1);
    wr_cfg(3, 32'hE000_0000); run(60);
    chk("R5 entry 14 -> 12", int'(d_div), 12);

    // R10 R11 R12: mixed traffic, compared per cycle by the harnesses
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      in_tick = ($urandom % 4) != 0;
      wr = '0;
      if (($urandom % 6) == 0) begin
        wr[$urandom % 4] = 1'b1;
        wdata = $urandom;
      end
    end
    wr = '0;
    run(5);
    done = 1;
    finish_up();
  end
endmodule